// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous request port and an external 16-bit asynchronous static RAM. The RAM has one upper and one lower byte enable. A user issues one access at a time with a valid/ready handshake. The controller then produces the address, chip enable, output enable, write enable, the byte enables and the data-bus drive, and returns read data with a one-cycle valid pulse.

Every analogue interval becomes a whole number of clock cycles when the design is elaborated. These intervals are the write pulse, data and address setup, read access, bus turnaround and the power-on wait. Each interval is a nanosecond minimum (held in picoseconds) divided by the clock period and rounded up. The controller always ends a write by raising write enable while chip enable and the byte enables stay low, so one edge is the timing reference for every write.

All pin outputs come straight from flip-flops. The data bus is split into output, input and output-enable so the tristate buffer can sit in the I/O cell.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `ready` stays low and `mem_ce_n` stays high for at least the power-on wait, which is 20000 cycles at the default 5 ns clock and 100 us setting. `ready` rises no later than 3 cycles after that.
- R2: `ready` is high only while no access is in progress, and chip enable is high whenever `ready` is high. A request is taken only on a clock edge where `ready` is high, and each accepted request makes exactly one memory access.
- R3: A write holds chip enable and write enable low together. Write enable is always the strobe that rises first. Chip enable and the selected byte enables stay low for one more cycle after that rising edge.
- R4: The write-enable low pulse lasts exactly WLOW cycles. WLOW is the largest of the write-pulse minimum, the address-to-write-end minimum, the write-turnaround time plus the data setup time, and the write cycle time minus one cycle. The default is 3 cycles.
- R5: The controller does not drive the data bus during the first write-turnaround interval after write enable falls. From that point it drives the write data for at least the data-setup interval before write enable rises, and keeps driving through the cycle that follows the rise.
- R6: On a write, mask bit 1 enables the upper lane (data bits 15:8) and mask bit 0 enables the lower lane (bits 7:0), with 1 meaning write that lane. A write with mask 00 changes no byte. A read pulls both byte enables low.
- R7: A read holds output enable low for exactly RACC cycles, which is 2 at the default. The controller captures the data bus on the last edge of that window and pulses `rd_valid` for one cycle with the captured data.
- R8: The controller never drives the data bus while output enable is low. After output enable rises, it leaves the bus undriven for at least the read-turnaround interval.
- R9: The memory address stays stable for as long as chip enable is low.
- R10: Each cycle count is the nanosecond minimum divided by the clock period and rounded up, and is at least one cycle when the minimum is nonzero. At 5 ns this gives a write pulse of 3 cycles and a read window of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select for writes, bit 1 upper, bit 0 lower |
| ready | output | 1 | Controller idle; request taken on this edge |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_i | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |

## Verification
A wrong state or a count that is off by one appears at the pins within the same access.

- A write pulse that is too short shows up as a write-enable width different from WLOW, or as data driven for too few cycles before the rising edge.
- A read window that is too short captures placeholder data, which the scoreboard reports on that read's `rd_valid`.
- A turnaround counter that leaks shows up in the bench's memory model as bus contention in the first cycle after output enable rises or write enable falls.
- A stuck state shows up as `ready` never returning, which the bench catches well within the run.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_IDLE = 3'd1,
    ST_WLOW = 3'd2,
    ST_WEND = 3'd3,
    ST_RACC = 3'd4,
    ST_RGAP = 3'd5
  } sram_st_e;

  // cycles needed to cover t_ps at a clock of clk_ps, rounded up
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    if (t_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup.sv
module sram_pwrup #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int LIM = (CYCLES > 0) ? CYCLES - 1 : 0;
  localparam int PW  = $clog2(LIM + 2);

  logic [PW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == PW'(LIM)) done_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = done_q;

  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

endmodule

// File: rtl/sram_fsm.sv
module sram_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WLOW = 3,
  parameter int RACC = 2,
  parameter int RGAP = 1,
  parameter int WHZ  = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pwr_done,
  input  logic     req_valid,
  input  logic     req_write,
  output sram_st_e st_q,
  output sram_st_e st_n,
  output logic     accept,
  output logic     drive_n,
  output logic     capture
);
  localparam int MAXC = imax(imax(WLOW, RACC), RGAP);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DRIVE_FROM = WLOW - 1 - WHZ;

  sram_st_e      st_r, st_c;
  logic [CW-1:0] cnt_q, cnt_c;
  logic          acc_c;

  always_comb begin
    st_c  = st_r;
    cnt_c = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    acc_c = 1'b0;
    case (st_r)
      ST_PWR:  if (pwr_done) st_c = ST_IDLE;
      ST_IDLE: if (req_valid) begin
        acc_c = 1'b1;
        if (req_write) begin
          st_c  = ST_WLOW;
          cnt_c = CW'(WLOW - 1);
        end else begin
          st_c  = ST_RACC;
          cnt_c = CW'(RACC - 1);
        end
      end
      ST_WLOW: if (cnt_q == '0) st_c = ST_WEND;
      ST_WEND: st_c = ST_IDLE;
      ST_RACC: if (cnt_q == '0) begin
        st_c  = ST_RGAP;
        cnt_c = CW'(RGAP - 1);
      end
      ST_RGAP: if (cnt_q == '0) st_c = ST_IDLE;
      default: st_c = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r  <= ST_PWR;
      cnt_q <= '0;
    end else begin
      st_r  <= st_c;
      cnt_q <= cnt_c;
    end
  end

  assign st_q    = st_r;
  assign st_n    = st_c;
  assign accept  = acc_c;
  assign capture = (st_r == ST_RACC) && (cnt_q == '0);
  assign drive_n = ((st_c == ST_WLOW) && (cnt_c <= CW'(DRIVE_FROM))) ||
                   (st_c == ST_WEND);

  assert_pwr_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !pwr_done |=> (st_r == ST_PWR));
  assert_write_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (st_r == ST_WLOW) |=> (st_r == ST_WLOW || st_r == ST_WEND));
  assert_read_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (st_r == ST_RACC) |=> (st_r == ST_RACC || st_r == ST_RGAP));

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  sram_st_e          st_n,
  input  logic              accept,
  input  logic              drive_n,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);
  logic [1:0] lanes_q, lanes_c;
  logic       active_c;

  assign lanes_c  = accept ? (req_write ? req_mask : 2'b11) : lanes_q;
  assign active_c = (st_n == ST_WLOW) || (st_n == ST_WEND) || (st_n == ST_RACC);

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes_q   <= 2'b00;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      ready     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      lanes_q <= lanes_c;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      mem_ce_n  <= !active_c;
      mem_we_n  <= !(st_n == ST_WLOW);
      mem_oe_n  <= !(st_n == ST_RACC);
      mem_ub_n  <= !(active_c && lanes_c[1]);
      mem_lb_n  <= !(active_c && lanes_c[0]);
      mem_dq_oe <= drive_n;
      ready     <= (st_n == ST_IDLE);
      rd_valid  <= capture;
      if (capture) rd_data <= mem_dq_i;
    end
  end

  assert_we_under_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);
  assert_we_ends_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_oe_n));
  assert_no_drive_at_we_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !mem_dq_oe);
  assert_drive_at_we_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);
  assert_no_drive_oe_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);
  assert_gap_after_oe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> !mem_dq_oe);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  assert_read_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ub_n && !mem_lb_n));
  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && !mem_dq_oe));
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int CLK_PS      = 5000,
  parameter int T_PWE_PS    = 7000,
  parameter int T_SD_PS     = 6000,
  parameter int T_AW_PS     = 7000,
  parameter int T_WC_PS     = 10000,
  parameter int T_AA_PS     = 10000,
  parameter int T_DOE_PS    = 5000,
  parameter int T_RC_PS     = 10000,
  parameter int T_HZOE_PS   = 5000,
  parameter int T_HZWE_PS   = 5000,
  parameter int T_PWRUP_PS  = 100000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              ready,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_o,
  input  logic [15:0]       mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int PWE_C  = cyc_of(T_PWE_PS,  CLK_PS);
  localparam int SD_C   = cyc_of(T_SD_PS,   CLK_PS);
  localparam int AW_C   = cyc_of(T_AW_PS,   CLK_PS);
  localparam int WC_C   = cyc_of(T_WC_PS,   CLK_PS);
  localparam int AA_C   = cyc_of(T_AA_PS,   CLK_PS);
  localparam int DOE_C  = cyc_of(T_DOE_PS,  CLK_PS);
  localparam int RC_C   = cyc_of(T_RC_PS,   CLK_PS);
  localparam int HZOE_C = cyc_of(T_HZOE_PS, CLK_PS);
  localparam int HZWE_C = cyc_of(T_HZWE_PS, CLK_PS);
  localparam int PWR_C  = cyc_of(T_PWRUP_PS, CLK_PS);

  // write-enable low time: pulse, address-to-end, turnaround+setup, cycle
  localparam int WLOW_C = imax(imax(PWE_C, AW_C),
                               imax(HZWE_C + imax(SD_C, 1), WC_C - 1));
  // read window: address access, output-enable access, cycle less gap
  localparam int RGAP_C = imax(HZOE_C, 1);
  localparam int RACC_C = imax(imax(AA_C, DOE_C), imax(RC_C - RGAP_C, 1));

  logic     pwr_done;
  sram_st_e st_q, st_n;
  logic     accept, drive_n, capture;

  sram_pwrup #(.CYCLES(PWR_C)) u_pwr (
    .clk  (clk),
    .rst  (rst),
    .done (pwr_done)
  );

  sram_fsm #(
    .WLOW (WLOW_C),
    .RACC (RACC_C),
    .RGAP (RGAP_C),
    .WHZ  (HZWE_C)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pwr_done  (pwr_done),
    .req_valid (req_valid),
    .req_write (req_write),
    .st_q      (st_q),
    .st_n      (st_n),
    .accept    (accept),
    .drive_n   (drive_n),
    .capture   (capture)
  );

  sram_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_n      (st_n),
    .accept    (accept),
    .drive_n   (drive_n),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_dq_i  (mem_dq_i),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  assert_pwr_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
    !pwr_done |-> (!ready && mem_ce_n));
  assert_take_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
    accept |-> ready);
  assert_idle_state_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> mem_ce_n);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
  localparam int AW = 10;
  localparam int PWR_EXP = 20000;
  localparam int WLOW_EXP = 3;
  localparam int RACC_EXP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = 2'b00;
  logic          ready, rd_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0]   mem_dq_o, mem_dq_i;

  sram_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe));

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model, one observation per cycle ----------------
  logic [15:0] mem [0:(1<<AW)-1];
  int  age = 0, we_run = 0, dq_run = 0, oe_run = 0;
  int  last_we = 0, last_oe = 0;
  bit  oe_prev = 0, we_prev = 0, ce_prev = 0;
  logic [AW-1:0] addr_prev = '0;
  int  v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0, v_r9 = 0;
  logic mdrive;

  initial for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h0000;

  assign mdrive   = (!mem_oe_n && !mem_ce_n) || oe_prev;
  assign mem_dq_i = mdrive ? ((!mem_oe_n && age >= 2) ? mem[mem_addr] : 16'hBAD0)
                           : 16'h0000;

  always @(negedge clk) if (!rst) begin
    bit oe_act;
    oe_act = !mem_oe_n && !mem_ce_n;
    if (mem_dq_oe && (oe_act || oe_prev)) v_r8++;
    if (oe_act) begin
      age++; oe_run++;
      if (mem_ub_n || mem_lb_n) v_r6++;
    end else begin
      age = 0;
      if (oe_run > 0) begin last_oe = oe_run; oe_run = 0; end
    end
    oe_prev = oe_act;
    if (!mem_we_n) begin
      we_run++;
      if (mem_dq_oe) dq_run++;
      if (mem_dq_oe && we_run <= 1) v_r5++;
      if (mem_ce_n) v_r3++;
    end else if (we_prev) begin
      last_we = we_run;
      if (we_run < 2) v_r4++;
      if (dq_run < 2 || !mem_dq_oe) v_r5++;
      if (mem_ce_n) v_r3++;
      else begin
        if (!mem_ub_n) mem[mem_addr][15:8] = mem_dq_o[15:8];
        if (!mem_lb_n) mem[mem_addr][7:0]  = mem_dq_o[7:0];
      end
      we_run = 0; dq_run = 0;
    end
    we_prev = !mem_we_n;
    if (!mem_ce_n && ce_prev && mem_addr != addr_prev) v_r9++;
    ce_prev = !mem_ce_n;
    addr_prev = mem_addr;
  end

  // ---------------- scoreboard ----------------
  logic [15:0] shadow [0:(1<<AW)-1];
  logic [15:0] expq [$];
  int rd_seen = 0, rd_issued = 0;

  initial for (int i = 0; i < (1<<AW); i++) shadow[i] = 16'h0000;

  always @(negedge clk) if (!rst && rd_valid) begin
    rd_seen++;
    if (expq.size() == 0) check(0, "R7 unexpected rd_valid", rd_data, 0);
    else begin
      logic [15:0] e;
      e = expq.pop_front();
      check(rd_data == e, "R7 read data", rd_data, e);
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    check(!ready, "R2 ready low in access", ready, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    if (m[1]) shadow[a][15:8] = d[15:8];
    if (m[0]) shadow[a][7:0]  = d[7:0];
    issue(1'b1, a, d, m);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    expq.push_back(shadow[a]);
    rd_issued++;
    issue(1'b0, a, 16'h0000, 2'b00);
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int t0;
    bit ce_seen;
    repeat (5) @(negedge clk);
    check(ready == 0 && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 reset state", {ready, mem_ce_n, mem_we_n, mem_oe_n}, 4'b0111);
    rst = 1'b0;
    t0 = cyc;
    // request during power-up must not start any access
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'd5; req_wdata = 16'hFFFF; req_mask = 2'b11;
    ce_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!mem_ce_n || ready) ce_seen = 1;
    end
    req_valid = 1'b0;
    check(!ce_seen, "R1 quiet during power-up", ce_seen, 0);
    while (!ready) begin
      @(negedge clk);
      if (!mem_ce_n) ce_seen = 1;
    end
    check(!ce_seen, "R1 no strobe before ready", ce_seen, 0);
    check((cyc - t0) >= PWR_EXP && (cyc - t0) <= PWR_EXP + 3,
          "R1 power-up length", cyc - t0, PWR_EXP);

    do_read(10'd5);                       // R1: early request was dropped
    do_write(10'd1, 16'h1234, 2'b11);
    wait_idle();
    check(last_we == WLOW_EXP, "R4 R10 write pulse cycles", last_we, WLOW_EXP);
    do_read(10'd1);
    wait_idle();
    check(last_oe == RACC_EXP, "R7 R10 read window cycles", last_oe, RACC_EXP);

    do_write(10'd2, 16'hAAAA, 2'b11);
    do_write(10'd2, 16'h5B6C, 2'b10);     // R6 upper lane only
    do_write(10'd3, 16'hCCCC, 2'b11);
    do_write(10'd3, 16'h7788, 2'b01);     // R6 lower lane only
    do_write(10'd4, 16'h4321, 2'b11);
    do_write(10'd4, 16'hFFFF, 2'b00);     // R6 no lane
    do_read(10'd2);
    do_read(10'd3);
    do_read(10'd4);

    for (int k = 0; k < 16; k++) begin
      do_write(AW'(k * 37 + 100), 16'(k * 16'h1111 ^ 16'h0F0F), 2'b11);
      do_read(AW'(k * 37 + 100));
    end
    for (int k = 0; k < 8; k++) do_read(AW'(k * 37 + 100));
    do_write(10'd1023, 16'hBEEF, 2'b11);
    do_read(10'd1023);
    do_read(10'd0);

    wait_idle();
    repeat (4) @(negedge clk);
    check(rd_seen == rd_issued, "R2 one access per request", rd_seen, rd_issued);
    check(expq.size() == 0, "R7 all reads returned", expq.size(), 0);
    check(v_r3 == 0, "R3 strobe order", v_r3, 0);
    check(v_r4 == 0, "R4 pulse width", v_r4, 0);
    check(v_r5 == 0, "R5 data drive window", v_r5, 0);
    check(v_r6 == 0, "R6 read lanes", v_r6, 0);
    check(v_r8 == 0, "R8 bus contention", v_r8, 0);
    check(v_r9 == 0, "R9 address stability", v_r9, 0);
    check(mem[4] == 16'h4321 && mem[2] == 16'h5BAA && mem[3] == 16'hCC88,
          "R6 model lanes", mem[2], 16'h5BAA);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule